// File: doc/BRIEF.md
# E1 CAS Signalling Multiframe Mapper

This block carries channel-associated ABCD signalling through time slot 16 of an E1 stream that is organised into 16-frame signalling multiframes. On the transmit side, software or a neighbouring block writes a 4-bit ABCD code for each of the 30 payload channels into a transmit table. Each time the framer asks for the time slot 16 octet of a given frame, the block returns either the multiframe alignment word (frame 0) or the pair of codes that belongs to that frame (frames 1 to 15).

On the receive side, the block takes the time slot 16 octet together with the frame number and a qualifying strobe. It splits the octet into two codes and stores them in a 30-entry receive table, which can be read by channel number at any time. Frame and multiframe alignment are not searched for here. The frame counters for both directions are inputs.

The transmit path is a small state machine with three named states. `TX_IDLE` means no octet is pending. `TX_ALIGN` means the alignment word for frame 0 is being presented. `TX_SIGNAL` means a signalling octet for frames 1 to 15 is being presented. On every clock edge the next state is chosen from `tx_ts16_req` and `tx_frame`:
- Idle/Align/Signal go to `TX_ALIGN` when a request names frame 0.
- They go to `TX_SIGNAL` when a request names any other frame.
- They go to `TX_IDLE` when there is no request.

Top module: `cas_mf_mapper`

## Requirements
- R1: After reset every transmit and receive table entry holds the idle code 1101, so any signalling octet is 0xDD and any receive read of channels 1..30 returns 1101.
- R2: A request for frame k (1..15) yields the octet {code of channel k, code of channel k+15}: channel k in bits 7:4, channel k+15 in bits 3:0, with A as the most significant bit of each nibble.
- R3: A request for frame 0 yields the alignment word 0000 in bits 7:4, ones in bits 3, 1 and 0, and the `tx_mf_alarm` input in bit 2 (0x0B without alarm, 0x0F with alarm).
- R4: `tx_ts16_valid` is high in the cycle after a request, low in the cycle after no request, and the octet holds its value while there is no request.
- R5: If a transmit write and a request that reads the same channel happen in the same cycle, the octet carries the old code. The new code appears from the next request.
- R6: When `rx_ts16_valid` is high with frame k (1..15), channel k takes bits 7:4 and channel k+15 takes bits 3:0 of the octet. `rx_rd_abcd` returns the stored code of `rx_rd_ch` combinationally, and it returns 0000 for channel numbers outside 1..30.
- R7: A receive octet with frame 0, or with `rx_ts16_valid` low, changes no receive entry.
- R8: A transmit write to channel 0 or to channels above 30 changes no transmit entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_frame | input | 4 | Transmit frame number within the multiframe |
| tx_ts16_req | input | 1 | Request for the time slot 16 octet of `tx_frame` |
| tx_mf_alarm | input | 1 | Remote multiframe alarm bit sent in the frame-0 word |
| tx_wr_en | input | 1 | Transmit table write strobe |
| tx_wr_ch | input | 5 | Channel number (1..30) to write |
| tx_wr_abcd | input | 4 | ABCD code to write |
| tx_ts16_octet | output | 8 | Time slot 16 octet |
| tx_ts16_valid | output | 1 | Octet presented for the previous request |
| rx_frame | input | 4 | Receive frame number within the multiframe |
| rx_ts16_valid | input | 1 | Strobe marking a received time slot 16 octet |
| rx_ts16_octet | input | 8 | Received time slot 16 octet |
| rx_rd_ch | input | 5 | Channel number to read from the receive table |
| rx_rd_abcd | output | 4 | Stored ABCD code of `rx_rd_ch` |

## Verification
Two operations can fall in the same cycle: a transmit table update and the octet build that reads the same entry. The bench provokes this by writing channel k, and also channel k+15, on the very edge where it requests frame k. It expects the octet to carry the codes from before the write, and it expects the following request for frame k to carry the new codes. The receive side is judged in the same way: a frame-0 or unqualified octet must leave every channel's read-back unchanged.

// File: rtl/cas_pkg.sv
package cas_pkg;
    typedef enum logic [1:0] {
        TX_IDLE   = 2'd0,
        TX_ALIGN  = 2'd1,
        TX_SIGNAL = 2'd2
    } tx_state_e;

    localparam logic [3:0] ABCD_IDLE   = 4'b1101;
    localparam logic [3:0] MF_ALIGN_NB = 4'b0000;
endpackage

// File: rtl/cas_sig_table.sv
module cas_sig_table #(
    parameter int NENT  = 30,
    parameter int W     = 4,
    parameter int IDX_W = 5,
    parameter int NWR   = 1,
    parameter int NRD   = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NWR-1:0]             wr_en,
    input  logic [NWR-1:0][IDX_W-1:0]  wr_idx,
    input  logic [NWR-1:0][W-1:0]      wr_data,
    input  logic [NRD-1:0][IDX_W-1:0]  rd_idx,
    output logic [NRD-1:0][W-1:0]      rd_data
);
    logic [W-1:0] mem [NENT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) mem[i] <= RST_VAL;
        end else begin
            for (int w = 0; w < NWR; w++) begin
                if (wr_en[w] && (int'(wr_idx[w]) < NENT))
                    mem[wr_idx[w]] <= wr_data[w];
            end
        end
    end

    for (genvar r = 0; r < NRD; r++) begin : g_rd
        assign rd_data[r] = (int'(rd_idx[r]) < NENT) ? mem[rd_idx[r]] : '0;
    end
endmodule

// File: rtl/cas_tx_framer.sv
module cas_tx_framer #(
    parameter int W    = 4,
    parameter int FN_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic [FN_W-1:0] frame,
    input  logic            mf_alarm,
    input  logic [W-1:0]    hi_code,
    input  logic [W-1:0]    lo_code,
    output logic [2*W-1:0]  octet,
    output logic            valid
);
    import cas_pkg::*;

    tx_state_e state_q, state_nx;

    always_comb begin
        if (!req)            state_nx = TX_IDLE;
        else if (frame == '0) state_nx = TX_ALIGN;
        else                 state_nx = TX_SIGNAL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            octet <= {ABCD_IDLE, ABCD_IDLE};
        end else begin
            unique case (state_nx)
                TX_ALIGN:  octet <= {MF_ALIGN_NB, 1'b1, mf_alarm, 2'b11};
                TX_SIGNAL: octet <= {hi_code, lo_code};
                default:   octet <= octet;
            endcase
        end
    end

    assign valid = (state_q != TX_IDLE);
endmodule

// File: rtl/cas_rx_demux.sv
module cas_rx_demux #(
    parameter int W     = 4,
    parameter int FN_W  = 4,
    parameter int IDX_W = 5,
    parameter int HALF  = 15
) (
    input  logic                    strobe,
    input  logic [FN_W-1:0]         frame,
    input  logic [2*W-1:0]          octet,
    output logic [1:0]              wr_en,
    output logic [1:0][IDX_W-1:0]   wr_idx,
    output logic [1:0][W-1:0]       wr_data
);
    logic [IDX_W-1:0] base;
    assign base       = IDX_W'(frame) - IDX_W'(1);
    assign wr_en      = {2{strobe && (frame != '0)}};
    assign wr_idx[0]  = base;
    assign wr_idx[1]  = base + IDX_W'(HALF);
    assign wr_data[0] = octet[2*W-1:W];
    assign wr_data[1] = octet[W-1:0];
endmodule

// File: rtl/cas_mf_mapper.sv
module cas_mf_mapper #(
    parameter int NCH    = 30,
    parameter int FRAMES = 16,
    parameter int W      = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [$clog2(FRAMES)-1:0]        tx_frame,
    input  logic                             tx_ts16_req,
    input  logic                             tx_mf_alarm,
    input  logic                             tx_wr_en,
    input  logic [$clog2(NCH+1)-1:0]         tx_wr_ch,
    input  logic [W-1:0]                     tx_wr_abcd,
    output logic [2*W-1:0]                   tx_ts16_octet,
    output logic                             tx_ts16_valid,
    input  logic [$clog2(FRAMES)-1:0]        rx_frame,
    input  logic                             rx_ts16_valid,
    input  logic [2*W-1:0]                   rx_ts16_octet,
    input  logic [$clog2(NCH+1)-1:0]         rx_rd_ch,
    output logic [W-1:0]                     rx_rd_abcd
);
    localparam int FN_W  = $clog2(FRAMES);
    localparam int IDX_W = $clog2(NCH + 1);
    localparam int HALF  = NCH / 2;

    // transmit table: one write port, two read ports (upper and lower nibble)
    logic [1:0][IDX_W-1:0] tx_rd_idx;
    logic [1:0][W-1:0]     tx_rd_code;
    logic [0:0][IDX_W-1:0] tx_w_idx;
    logic [0:0][W-1:0]     tx_w_data;

    assign tx_w_idx[0]  = tx_wr_ch - IDX_W'(1);
    assign tx_w_data[0] = tx_wr_abcd;
    assign tx_rd_idx[0] = IDX_W'(tx_frame) - IDX_W'(1);
    assign tx_rd_idx[1] = IDX_W'(tx_frame) - IDX_W'(1) + IDX_W'(HALF);

    cas_sig_table #(
        .NENT(NCH), .W(W), .IDX_W(IDX_W), .NWR(1), .NRD(2),
        .RST_VAL(cas_pkg::ABCD_IDLE)
    ) i_tx_tab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(tx_wr_en), .wr_idx(tx_w_idx), .wr_data(tx_w_data),
        .rd_idx(tx_rd_idx), .rd_data(tx_rd_code)
    );

    cas_tx_framer #(.W(W), .FN_W(FN_W)) i_framer (
        .clk(clk), .rst_n(rst_n),
        .req(tx_ts16_req), .frame(tx_frame), .mf_alarm(tx_mf_alarm),
        .hi_code(tx_rd_code[0]), .lo_code(tx_rd_code[1]),
        .octet(tx_ts16_octet), .valid(tx_ts16_valid)
    );

    // receive table: two write ports from the demux, one read port
    logic [1:0]            rx_w_en;
    logic [1:0][IDX_W-1:0] rx_w_idx;
    logic [1:0][W-1:0]     rx_w_data;
    logic [0:0][IDX_W-1:0] rx_r_idx;
    logic [0:0][W-1:0]     rx_r_code;

    cas_rx_demux #(.W(W), .FN_W(FN_W), .IDX_W(IDX_W), .HALF(HALF)) i_demux (
        .strobe(rx_ts16_valid), .frame(rx_frame), .octet(rx_ts16_octet),
        .wr_en(rx_w_en), .wr_idx(rx_w_idx), .wr_data(rx_w_data)
    );

    assign rx_r_idx[0] = rx_rd_ch - IDX_W'(1);

    cas_sig_table #(
        .NENT(NCH), .W(W), .IDX_W(IDX_W), .NWR(2), .NRD(1),
        .RST_VAL(cas_pkg::ABCD_IDLE)
    ) i_rx_tab (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rx_w_en), .wr_idx(rx_w_idx), .wr_data(rx_w_data),
        .rd_idx(rx_r_idx), .rd_data(rx_r_code)
    );

    assign rx_rd_abcd = rx_r_code[0];
endmodule

// File: rtl/cas_mf_checker.sv
module cas_mf_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] tx_frame,
    input logic       tx_ts16_req,
    input logic       tx_mf_alarm,
    input logic [7:0] tx_ts16_octet,
    input logic       tx_ts16_valid,
    input logic [3:0] rx_frame,
    input logic       rx_ts16_valid,
    input logic [4:0] rx_rd_ch,
    input logic [3:0] rx_rd_abcd
);
    // R3
    mf_align_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ts16_req && tx_frame == 4'd0) |=>
            (tx_ts16_octet[7:3] == 5'b00001 && tx_ts16_octet[1:0] == 2'b11));

    // R3
    mf_alarm_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ts16_req && tx_frame == 4'd0) |=> (tx_ts16_octet[2] == $past(tx_mf_alarm)));

    // R4
    valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ts16_req |=> tx_ts16_valid);

    // R4
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_ts16_req |=> (!tx_ts16_valid && $stable(tx_ts16_octet)));

    // R7
    rx_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!rx_ts16_valid || rx_frame == 4'd0) && $past(rst_n)) |=>
            ($stable(rx_rd_ch) -> $stable(rx_rd_abcd)));
endmodule

bind cas_mf_mapper cas_mf_checker i_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_frame(tx_frame), .tx_ts16_req(tx_ts16_req), .tx_mf_alarm(tx_mf_alarm),
    .tx_ts16_octet(tx_ts16_octet), .tx_ts16_valid(tx_ts16_valid),
    .rx_frame(rx_frame), .rx_ts16_valid(rx_ts16_valid),
    .rx_rd_ch(rx_rd_ch), .rx_rd_abcd(rx_rd_abcd)
);

// File: tb/test_cas_mf_mapper.sv
module test_cas_mf_mapper;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] tx_frame;
    logic       tx_ts16_req;
    logic       tx_mf_alarm;
    logic       tx_wr_en;
    logic [4:0] tx_wr_ch;
    logic [3:0] tx_wr_abcd;
    logic [7:0] tx_ts16_octet;
    logic       tx_ts16_valid;
    logic [3:0] rx_frame;
    logic       rx_ts16_valid;
    logic [7:0] rx_ts16_octet;
    logic [4:0] rx_rd_ch;
    logic [3:0] rx_rd_abcd;

    int n_run = 0;
    int n_fail = 0;
    logic [3:0] tx_m [1:30];
    logic [3:0] rx_m [1:30];

    always #4 clk = ~clk;

    cas_mf_mapper i_cas_mf_mapper (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tx_request(input logic [3:0] fr);
        @(negedge clk);
        tx_frame = fr; tx_ts16_req = 1'b1;
        @(negedge clk);
        tx_ts16_req = 1'b0;
    endtask

    task automatic tx_write(input logic [4:0] ch, input logic [3:0] code);
        @(negedge clk);
        tx_wr_en = 1'b1; tx_wr_ch = ch; tx_wr_abcd = code;
        @(negedge clk);
        tx_wr_en = 1'b0;
        if (ch >= 1 && ch <= 30) tx_m[ch] = code;
    endtask

    task automatic rx_push(input logic v, input logic [3:0] fr, input logic [7:0] oc);
        @(negedge clk);
        rx_ts16_valid = v; rx_frame = fr; rx_ts16_octet = oc;
        @(negedge clk);
        rx_ts16_valid = 1'b0;
        if (v && fr != 0) begin
            rx_m[fr] = oc[7:4];
            rx_m[fr + 15] = oc[3:0];
        end
    endtask

    task automatic check_rx_all(string req);
        for (int c = 1; c <= 30; c++) begin
            rx_rd_ch = 5'(c);
            #1;
            check(req, {4'h0, rx_rd_abcd}, {4'h0, rx_m[c]});
        end
    endtask

    task automatic check_tx_all(string req);
        for (int f = 1; f <= 15; f++) begin
            tx_request(4'(f));
            check(req, tx_ts16_octet, {tx_m[f], tx_m[f + 15]});
        end
    endtask

    task automatic t_reset;
        check_rx_all("R1 rx idle");
        tx_request(4'd5);
        check("R1 tx idle octet", tx_ts16_octet, 8'hDD);
        check("R4 valid after req", {7'b0, tx_ts16_valid}, 8'h01);
    endtask

    task automatic t_align;
        tx_mf_alarm = 1'b0;
        tx_request(4'd0);
        check("R3 align no alarm", tx_ts16_octet, 8'h0B);
        tx_mf_alarm = 1'b1;
        tx_request(4'd0);
        check("R3 align alarm", tx_ts16_octet, 8'h0F);
        tx_mf_alarm = 1'b0;
        @(negedge clk);
        check("R4 valid low idle", {7'b0, tx_ts16_valid}, 8'h00);
        check("R4 octet held", tx_ts16_octet, 8'h0F);
    endtask

    task automatic t_mapping;
        tx_write(5'd3, 4'h5);
        tx_write(5'd18, 4'hA);
        tx_write(5'd15, 4'h1);
        tx_write(5'd30, 4'h8);
        tx_request(4'd3);
        check("R2 frame 3", tx_ts16_octet, 8'h5A);
        tx_request(4'd15);
        check("R2 frame 15", tx_ts16_octet, 8'h18);
        check_tx_all("R2 all frames");
    endtask

    task automatic t_collide;
        @(negedge clk);
        tx_frame = 4'd7; tx_ts16_req = 1'b1;
        tx_wr_en = 1'b1; tx_wr_ch = 5'd7; tx_wr_abcd = 4'h3;
        @(negedge clk);
        tx_ts16_req = 1'b0; tx_wr_en = 1'b0;
        check("R5 old value on collision", tx_ts16_octet, {tx_m[7], tx_m[22]});
        tx_m[7] = 4'h3;
        @(negedge clk);
        tx_frame = 4'd7; tx_ts16_req = 1'b1;
        tx_wr_en = 1'b1; tx_wr_ch = 5'd22; tx_wr_abcd = 4'h6;
        @(negedge clk);
        tx_ts16_req = 1'b0; tx_wr_en = 1'b0;
        check("R5 new upper, old lower", tx_ts16_octet, {4'h3, tx_m[22]});
        tx_m[22] = 4'h6;
        tx_request(4'd7);
        check("R5 new value next req", tx_ts16_octet, 8'h36);
    endtask

    task automatic t_bad_write;
        tx_write(5'd0, 4'h0);
        tx_write(5'd31, 4'h0);
        check_tx_all("R8 out-of-range write ignored");
    endtask

    task automatic t_rx;
        rx_push(1'b1, 4'd4, 8'h9C);
        rx_rd_ch = 5'd4; #1;
        check("R6 rx upper", {4'h0, rx_rd_abcd}, 8'h09);
        rx_rd_ch = 5'd19; #1;
        check("R6 rx lower", {4'h0, rx_rd_abcd}, 8'h0C);
        rx_push(1'b1, 4'd15, 8'h27);
        rx_push(1'b1, 4'd1, 8'hE4);
        check_rx_all("R6 rx table");
        rx_rd_ch = 5'd0; #1;
        check("R6 rx read ch0", {4'h0, rx_rd_abcd}, 8'h00);
        rx_rd_ch = 5'd31; #1;
        check("R6 rx read ch31", {4'h0, rx_rd_abcd}, 8'h00);
        rx_push(1'b1, 4'd0, 8'h00);
        check_rx_all("R7 frame 0 ignored");
        rx_push(1'b0, 4'd4, 8'h00);
        check_rx_all("R7 no strobe ignored");
    endtask

    initial begin
        #150000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; tx_frame = '0; tx_ts16_req = 1'b0; tx_mf_alarm = 1'b0;
        tx_wr_en = 1'b0; tx_wr_ch = '0; tx_wr_abcd = '0;
        rx_frame = '0; rx_ts16_valid = 1'b0; rx_ts16_octet = '0; rx_rd_ch = 5'd1;
        for (int c = 1; c <= 30; c++) begin
            tx_m[c] = 4'b1101;
            rx_m[c] = 4'b1101;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R4 valid low after reset", {7'b0, tx_ts16_valid}, 8'h00);
        t_reset();
        t_align();
        t_mapping();
        t_collide();
        t_bad_write();
        t_rx();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule